// File: doc/BRIEF.md
# Serial-Loaded LED Channel Sink Controller

This block is the digital core of a cascadable sixteen-channel LED sink driver. A host shifts one bit per step into a sixteen-bit serial register. The register's last stage is driven on a serial output so that several devices can be chained. A level-sensitive latch copies the register while the latch-enable input is high and holds its value while the input is low. An active-low output enable, an undervoltage lockout and a thermal trip then gate the latched bits into sixteen registered channel-enable outputs.

The two fault paths have different reset rules. Undervoltage passes through a two-flop synchronizer into a two-state guard, RUN and LOCKOUT. RUN moves to LOCKOUT when the synchronized flag is high. LOCKOUT moves to RUN when the flag drops, and that same clock edge clears the serial register and the latch. Thermal protection is a two-state machine, COOL and HOT. COOL moves to HOT when the temperature code is above the trip threshold. HOT moves back to COOL when the code is below a lower release threshold. While HOT, the outputs are blanked, but the stored data is kept and shifting and latching continue.

Top module: `led_sink_ctrl`

## Requirements
- R1: On a rising clock edge with `shift_step` high, `sdi` enters register bit 0 and every bit moves up one place. With `shift_step` low, the register keeps its contents whatever `sdi` does.
- R2: `sdo` always shows register bit 15. A word loaded earlier leaves on `sdo` during the next 16 steps, in the order it was shifted in.
- R3: While `le` is high the latch is transparent, and `ch_en` shows the register contents one clock later. While `le` is low the latch holds its contents, even while new data is shifted.
- R4: Latch bit i drives `ch_en[i]`. After 16 steps, the first bit shifted in lands on channel 15 and the last on channel 0.
- R5: With `oe_n` high, every bit of `ch_en` is 0 from the next clock. With `oe_n` low, `ch_en` follows the latch again, and the latch contents are not disturbed.
- R6: After reset, the register, the latch, `ch_en`, `sdo` and `fault` are all 0.
- R7: `uv_in` is synchronized through two flops. Three clocks after it rises, `fault[0]` (undervoltage) is 1, and from the next clock `ch_en` is all 0.
- R8: When the guard leaves LOCKOUT, the register and the latch are cleared to 0. Re-latching then gives `ch_en` = 0, and `sdo` shifts out zeros.
- R9: A temperature code above 150 sets `fault[1]` (thermal) on the next clock, and `ch_en` is 0 from the clock after that.
- R10: `fault[1]` clears on the clock after the code is below 135. For codes from 135 to 150 inclusive, the flag keeps its previous value.
- R11: Thermal shutdown does not clear stored data. After the flag clears, `ch_en` shows the earlier latched pattern again without a reload, and the register contents are intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| shift_step | input | 1 | Shift qualifier: register advances on edges where high |
| sdi | input | 1 | Serial data in |
| le | input | 1 | Latch enable, transparent when high |
| oe_n | input | 1 | Active-low output enable |
| uv_in | input | 1 | Asynchronous undervoltage flag |
| temp_c | input | 8 | Junction temperature, unsigned whole degrees C |
| sdo | output | 1 | Serial data out (register bit 15) |
| ch_en | output | 16 | Registered channel enables |
| fault | output | 2 | Bit 0 undervoltage lockout, bit 1 thermal shutdown |

## Verification
The bench sweeps the temperature code one degree at a time upward through the trip point and back down through the release point. A design with the hysteresis missing or the thresholds off by one would flip the flag at the wrong code. Walking-one words check the bit-to-channel mapping and would catch a reversed shift. Cascade shifting checks that an earlier word leaves on `sdo` in order while the held latch stays unchanged. The bench also checks that the undervoltage recovery clears the stored data, while the thermal recovery restores the old pattern, so a design that swapped the two reset rules fails one of them.

// File: rtl/led_sink_pkg.sv
package led_sink_pkg;

    typedef enum logic {
        UV_RUN     = 1'b0,
        UV_LOCKOUT = 1'b1
    } uv_state_t;

    typedef enum logic {
        TH_COOL = 1'b0,
        TH_HOT  = 1'b1
    } th_state_t;

    localparam int FLT_UV = 0;
    localparam int FLT_TH = 1;
    localparam int FLT_W  = 2;

endpackage

// File: rtl/led_shift_chain.sv
module led_shift_chain #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         step,
    input  logic         sdi,
    output logic [N-1:0] sr_q,
    output logic         sdo
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sr_q <= '0;
        else if (clr)
            sr_q <= '0;
        else if (step)
            sr_q <= {sr_q[N-2:0], sdi};
    end

    assign sdo = sr_q[N-1];

    // R1
    shift_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step && !clr |=> sr_q[0] == $past(sdi) && sr_q[N-1:1] == $past(sr_q[N-2:0]));

    // R1
    shift_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step && !clr |=> $stable(sr_q));

endmodule

// File: rtl/led_latch_bank.sv
module led_latch_bank #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         le,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);

    logic [N-1:0] hold_q;

    // Level-sensitive behaviour: transparent path while enabled.
    always_comb q = le ? d : hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hold_q <= '0;
        else if (clr)
            hold_q <= '0;
        else
            hold_q <= q;
    end

    // R3
    latch_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        le && !clr |=> hold_q == $past(d));

    // R3
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !le && !clr |=> $stable(hold_q));

endmodule

// File: rtl/led_thermal_fsm.sv
module led_thermal_fsm
    import led_sink_pkg::*;
#(
    parameter int          TW     = 8,
    parameter int unsigned TRIP   = 150,
    parameter int unsigned RELEASE = 135
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] temp,
    output logic          hot
);

    localparam logic [TW-1:0] TRIP_C = TW'(TRIP);
    localparam logic [TW-1:0] REL_C  = TW'(RELEASE);

    th_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= TH_COOL;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TH_COOL: if (temp > TRIP_C) state_d = TH_HOT;
            TH_HOT:  if (temp < REL_C)  state_d = TH_COOL;
            default: state_d = TH_COOL;
        endcase
    end

    assign hot = (state_q == TH_HOT);

    // R9
    th_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        temp > TRIP_C |=> hot);

    // R10
    th_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        temp < REL_C |=> !hot);

    // R10
    th_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
        temp >= REL_C && temp <= TRIP_C |=> hot == $past(hot));

endmodule

// File: rtl/led_uv_guard.sv
module led_uv_guard
    import led_sink_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic uv_in,
    output logic lockout,
    output logic clr_pulse
);

    logic      sync1_q, uv_s;
    uv_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            uv_s    <= 1'b0;
        end else begin
            sync1_q <= uv_in;
            uv_s    <= sync1_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= UV_RUN;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        clr_pulse = 1'b0;
        unique case (state_q)
            UV_RUN:     if (uv_s) state_d = UV_LOCKOUT;
            UV_LOCKOUT: if (!uv_s) begin
                state_d   = UV_RUN;
                clr_pulse = 1'b1;
            end
            default:    state_d = UV_RUN;
        endcase
    end

    assign lockout = (state_q == UV_LOCKOUT);

    // R7
    uv_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uv_s |=> lockout);

    // R8
    uv_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lockout && !uv_s |=> !lockout);

endmodule

// File: rtl/led_sink_ctrl.sv
module led_sink_ctrl
    import led_sink_pkg::*;
#(
    parameter int          N        = 16,
    parameter int          TW       = 8,
    parameter int unsigned TRIP_C   = 150,
    parameter int unsigned RELEASE_C = 135
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_step,
    input  logic             sdi,
    input  logic             le,
    input  logic             oe_n,
    input  logic             uv_in,
    input  logic [TW-1:0]    temp_c,
    output logic             sdo,
    output logic [N-1:0]     ch_en,
    output logic [FLT_W-1:0] fault
);

    logic         lockout, clr_pulse, hot, drive_ok;
    logic [N-1:0] sr_w, lat_w;

    led_uv_guard u_uv (
        .clk       (clk),
        .rst_n     (rst_n),
        .uv_in     (uv_in),
        .lockout   (lockout),
        .clr_pulse (clr_pulse)
    );

    led_thermal_fsm #(
        .TW      (TW),
        .TRIP    (TRIP_C),
        .RELEASE (RELEASE_C)
    ) u_th (
        .clk   (clk),
        .rst_n (rst_n),
        .temp  (temp_c),
        .hot   (hot)
    );

    led_shift_chain #(.N(N)) u_sr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_pulse),
        .step  (shift_step),
        .sdi   (sdi),
        .sr_q  (sr_w),
        .sdo   (sdo)
    );

    led_latch_bank #(.N(N)) u_lat (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_pulse),
        .le    (le),
        .d     (sr_w),
        .q     (lat_w)
    );

    assign drive_ok = !oe_n && !lockout && !hot;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ch_en <= '0;
        else
            ch_en <= lat_w & {N{drive_ok}};
    end

    always_comb begin
        fault         = '0;
        fault[FLT_UV] = lockout;
        fault[FLT_TH] = hot;
    end

    // R5
    oe_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |=> ch_en == '0);

    // R7
    uv_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lockout |=> ch_en == '0);

    // R9
    th_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hot |=> ch_en == '0);

    // R8
    uv_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lockout) |-> sr_w == '0 && lat_w == '0);

    // R4
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n && !lockout && !hot |=> ch_en == $past(lat_w));

endmodule

// File: tb/led_sink_ctrl_test.sv
module led_sink_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        shift_step = 1'b0;
    logic        sdi = 1'b0;
    logic        le = 1'b0;
    logic        oe_n = 1'b0;
    logic        uv_in = 1'b0;
    logic [7:0]  temp_c = 8'd25;
    logic        sdo;
    logic [15:0] ch_en;
    logic [1:0]  fault;

    int total = 0;
    int bad = 0;
    bit done = 0;

    led_sink_ctrl uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_step (shift_step),
        .sdi        (sdi),
        .le         (le),
        .oe_n       (oe_n),
        .uv_in      (uv_in),
        .temp_c     (temp_c),
        .sdo        (sdo),
        .ch_en      (ch_en),
        .fault      (fault)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_word(input logic [15:0] w);
        for (int i = 15; i >= 0; i--) begin
            sdi = w[i];
            shift_step = 1'b1;
            @(negedge clk);
        end
        shift_step = 1'b0;
        sdi = 1'b0;
    endtask

    task automatic latch_pulse();
        le = 1'b1;
        @(negedge clk);
        le = 1'b0;
    endtask

    initial begin
        logic [15:0] pat, a, b, c, exp_sr;
        logic hot;

        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        check("R6 ch_en", ch_en, 0);
        check("R6 fault", fault, 0);
        check("R6 sdo", sdo, 0);
        latch_pulse();
        cyc(1);
        check("R6 latch", ch_en, 0);

        // R4: walking ones, first bit shifted lands on channel 15
        for (int k = 0; k < 16; k++) begin
            pat = 16'h1 << k;
            shift_word(pat);
            latch_pulse();
            check("R4 walk", ch_en, pat);
        end
        shift_word(16'hFFFF); latch_pulse();
        check("R4 ones", ch_en, 16'hFFFF);
        shift_word(16'hA5C3); latch_pulse();
        check("R4 mixed", ch_en, 16'hA5C3);

        // R1: idle register ignores sdi
        a = 16'h3C96;
        shift_word(a);
        for (int i = 0; i < 5; i++) begin sdi = i[0]; cyc(1); end
        sdi = 1'b0;
        latch_pulse();
        check("R1 idle", ch_en, a);

        // R2 cascade + R3 hold: shift b out while latch holds a
        b = 16'h5E21;
        for (int i = 15; i >= 0; i--) begin
            check("R2 sdo", sdo, a[i]);
            sdi = b[i]; shift_step = 1'b1;
            cyc(1);
        end
        shift_step = 1'b0;
        check("R3 hold", ch_en, a);
        check("R2 sdo next", sdo, b[15]);

        // R3 transparent: le high while shifting
        c = 16'hC71B;
        le = 1'b1;
        for (int i = 15; i >= 8; i--) begin
            sdi = c[i]; shift_step = 1'b1; cyc(1);
        end
        shift_step = 1'b0;
        cyc(1);
        exp_sr = {b[7:0], c[15:8]};
        check("R3 transparent half", ch_en, exp_sr);
        for (int i = 7; i >= 0; i--) begin
            sdi = c[i]; shift_step = 1'b1; cyc(1);
        end
        shift_step = 1'b0;
        cyc(1);
        check("R3 transparent full", ch_en, c);
        le = 1'b0;
        cyc(1);

        // R5 output enable
        oe_n = 1'b1; cyc(1);
        check("R5 blank", ch_en, 0);
        cyc(3);
        check("R5 blank hold", ch_en, 0);
        oe_n = 1'b0; cyc(1);
        check("R5 restore", ch_en, c);

        // R9/R10 thermal sweep with hysteresis
        pat = 16'h5A3C;
        shift_word(pat); latch_pulse();
        check("R9 preload", ch_en, pat);
        hot = 1'b0;
        for (int s = 0; s < 202; s++) begin
            int t;
            t = (s <= 100) ? 100 + s : 301 - s;
            temp_c = 8'(t);
            cyc(1);
            if (t > 150) hot = 1'b1;
            else if (t < 135) hot = 1'b0;
            check(t > 150 ? "R9 flag" : "R10 flag", fault[1], hot);
            cyc(1);
            check(t > 150 ? "R9 blank" : "R10 out", ch_en, hot ? 16'h0 : pat);
        end
        temp_c = 8'd25;
        cyc(2);
        check("R11 restored", ch_en, pat);
        check("R11 sdo", sdo, pat[15]);

        // R11: register keeps working during trip
        temp_c = 8'd160; cyc(2);
        shift_word(16'h0F0F); latch_pulse();
        check("R11 blanked", ch_en, 0);
        temp_c = 8'd100; cyc(2);
        check("R11 new data", ch_en, 16'h0F0F);

        // R7 undervoltage lockout
        shift_word(16'hBEEF); latch_pulse();
        uv_in = 1'b1;
        cyc(2);
        check("R7 sync delay", fault[0], 0);
        cyc(1);
        check("R7 flag", fault[0], 1);
        cyc(1);
        check("R7 blank", ch_en, 0);
        // R8 recovery clears everything
        uv_in = 1'b0;
        cyc(5);
        check("R8 flag", fault[0], 0);
        check("R8 ch_en", ch_en, 0);
        latch_pulse();
        check("R8 latch", ch_en, 0);
        for (int i = 0; i < 16; i++) begin
            check("R8 sdo", sdo, 0);
            sdi = 1'b1; shift_step = 1'b1; cyc(1);
        end
        shift_step = 1'b0;
        latch_pulse();
        check("R8 reload", ch_en, 16'hFFFF);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule